// File: doc/BRIEF.md
# Late-Write Synchronous Burst SRAM

This block is a synthesizable single-port synchronous memory. It samples commands, addresses, byte enables and chip selects on a rising clock edge. Read data flows through: it appears in the cycle right after the read command. Write data is taken one enabled edge after its write command. Because a read also returns its data one cycle after its command, the data bus carries one transfer per cycle in any mix of reads and writes, with no idle cycle between them.

Each write passes through a pending-write register before it reaches the array. A read that targets the address of the pending write gets the pending bytes, merged lane by lane with the stored word. A burst-advance input steps an internal two-bit offset counter through four addresses, in linear or interleaved order. Three chip-select inputs decide on every command edge whether the device takes part. An active-low clock enable freezes the whole block. An asynchronous output enable gates the read data without affecting any stored state. The tristate data bus is split into a data input, a data output and an output-valid flag.

Top module: `lw_burst_sram`

## Requirements
- R1: An enabled edge with `adv`=0, the block selected and `rw_n`=0 registers a write command, and `dout_vld` is low in the following cycle. The data on `din` at the next enabled edge is written to the command's address.
- R2: An enabled edge with `adv`=0, the block selected and `rw_n`=1 registers a read. In the following cycle, with `oe_n` low, `dout_vld` is high and `dout` holds the word at that address.
- R3: A read of an address at the edge right after a write command to that same address returns the newly written data. No idle cycle is needed.
- R4: Bit i of `byte_we_n` is active low and enables lane i, which is `din[9i+8:9i]`. Lanes whose bit is high keep their stored value.
- R5: While `adv`=1 on an enabled edge, `addr`, the chip selects and `rw_n` are ignored and the previous operation continues at the next burst address. A deselected device stays deselected.
- R6: When `burst_ilv`=0 is sampled with the command, the two low address bits of step n are (start + n) mod 4. The upper address bits stay fixed.
- R7: When `burst_ilv`=1 is sampled with the command, the two low address bits of step n are start XOR n.
- R8: An edge with `clk_en_n`=1 changes nothing. Outputs stay the same, a pending late-write data slot still waits, and `din` is not taken on that edge.
- R9: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A command edge with any other combination makes `dout_vld` low in the next cycle and writes nothing.
- R10: `oe_n`=1 forces `dout_vld` low at once, without a clock edge, and it does not stop writes.
- R11: A synchronous reset (`rst_n`=0 on an edge) leaves the block deselected, with `dout_vld` low.
- R12: `dout` is all zeros whenever `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| rw_n | input | 1 | 1 = read, 0 = write |
| adv | input | 1 | Burst advance; 1 continues the current burst |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW (10) | Word address |
| byte_we_n | input | LANES (4) | Active-low per-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | DW (36) | Write data, taken one enabled edge after its command |
| dout | output | DW (36) | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid (stands in for the driven bus) |

## Verification
The bench targets a read that lands on the address of a write whose data is still pending. A design without the bypass would return the old word, or a word with the byte lanes merged wrongly. It runs write and read bursts from non-zero start offsets in both orders, including the wrap past offset 3. Here an adder used in place of the XOR, or a counter that fails to wrap, would read the wrong word. It also holds the clock enable high with junk on `din` during a late-write data slot, and sends a write command while deselected with junk data after it. A design that took `din` on a frozen edge, or stored a deselected write, would then read back the junk.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

   // number of address bits that a burst walks through (four beats)
   localparam int BURST_BITS = 2;

   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } op_e;

   // low address bits of burst beat 'step' counted from 'start'
   function automatic logic [BURST_BITS-1:0] burst_offset(
      input logic [BURST_BITS-1:0] start,
      input logic [BURST_BITS-1:0] step,
      input logic                  ilv
   );
      logic [BURST_BITS-1:0] res;
      if (ilv) res = start ^ step;
      else     res = start + step;
      return res;
   endfunction

endpackage

// File: rtl/lw_burst_ctrl.sv
module lw_burst_ctrl
   import lw_sram_pkg::*;
#(
   parameter int AW    = 10,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             adv,
   input  logic             sel,
   input  logic             rw_n,
   input  logic             ilv,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] be_n,
   output logic             act,
   output op_e              op,
   output logic [AW-1:0]    cur_addr,
   output logic [LANES-1:0] cur_be
);

   localparam int HI_W = AW - BURST_BITS;

   logic                  act_q;
   op_e                   op_q;
   logic [HI_W-1:0]       base_q;
   logic [BURST_BITS-1:0] start_q;
   logic [BURST_BITS-1:0] step_q;
   logic                  ilv_q;
   logic [LANES-1:0]      be_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         op_q    <= OP_READ;
         base_q  <= '0;
         start_q <= '0;
         step_q  <= '0;
         ilv_q   <= 1'b0;
         be_q    <= '0;
      end else if (ce) begin
         if (!adv) begin
            act_q   <= sel;
            op_q    <= rw_n ? OP_READ : OP_WRITE;
            base_q  <= addr[AW-1:BURST_BITS];
            start_q <= addr[BURST_BITS-1:0];
            step_q  <= '0;
            ilv_q   <= ilv;
         end else begin
            step_q  <= step_q + BURST_BITS'(1);
         end
         // lane enables are taken on every edge, burst beats included
         be_q <= ~be_n;
      end
   end

   assign act      = act_q;
   assign op       = op_q;
   assign cur_addr = {base_q, burst_offset(start_q, step_q, ilv_q)};
   assign cur_be   = be_q;

endmodule

// File: rtl/lw_late_wr.sv
module lw_late_wr #(
   parameter int AW     = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   // write command registered on the previous enabled edge
   input  logic             cap,
   input  logic [AW-1:0]    cap_addr,
   input  logic [LANES-1:0] cap_be,
   input  logic [DW-1:0]    din,
   // pending write, committed to the array on the next enabled edge
   output logic             pend_v,
   output logic [AW-1:0]    pend_addr,
   output logic [LANES-1:0] pend_be,
   output logic [DW-1:0]    pend_data,
   // read bypass
   input  logic [AW-1:0]    rd_addr,
   input  logic [DW-1:0]    rd_word,
   output logic [DW-1:0]    rd_merged
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_addr <= '0;
         pend_be   <= '0;
         pend_data <= '0;
      end else if (ce) begin
         pend_v    <= cap;
         pend_addr <= cap_addr;
         pend_be   <= cap_be;
         pend_data <= din;
      end
   end

   logic hit;
   assign hit = pend_v && (pend_addr == rd_addr);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign rd_merged[l*LANE_W +: LANE_W] = (hit && pend_be[l])
                                           ? pend_data[l*LANE_W +: LANE_W]
                                           : rd_word[l*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
   parameter int DEPTH  = 1024,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [LANES-1:0] wbe,
   input  logic [DW-1:0]    wdata,
   input  logic [AW-1:0]    raddr,
   output logic [DW-1:0]    rdata
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wbe[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
      end

      assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
   end

endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram #(
   parameter int DEPTH  = 1024,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic             sel_a_n,
   input  logic             sel_b,
   input  logic             sel_c_n,
   input  logic             rw_n,
   input  logic             adv,
   input  logic             burst_ilv,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] byte_we_n,
   input  logic             oe_n,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dout,
   output logic             dout_vld
);

   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("lw_burst_sram: DEPTH must be a power of two and at least 4");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("lw_burst_sram: LANES and LANE_W must be positive");
   end

   logic                 ce;
   logic                 sel;
   logic                 act;
   lw_sram_pkg::op_e     op;
   logic [AW-1:0]        cur_addr;
   logic [LANES-1:0]     cur_be;
   logic                 pend_v;
   logic [AW-1:0]        pend_addr;
   logic [LANES-1:0]     pend_be;
   logic [DW-1:0]        pend_data;
   logic [DW-1:0]        arr_word;
   logic [DW-1:0]        rd_word;

   assign ce  = !clk_en_n;
   assign sel = !sel_a_n && sel_b && !sel_c_n;

   lw_burst_ctrl #(
      .AW    (AW),
      .LANES (LANES)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce       (ce),
      .adv      (adv),
      .sel      (sel),
      .rw_n     (rw_n),
      .ilv      (burst_ilv),
      .addr     (addr),
      .be_n     (byte_we_n),
      .act      (act),
      .op       (op),
      .cur_addr (cur_addr),
      .cur_be   (cur_be)
   );

   lw_late_wr #(
      .AW     (AW),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce        (ce),
      .cap       (act && op == lw_sram_pkg::OP_WRITE),
      .cap_addr  (cur_addr),
      .cap_be    (cur_be),
      .din       (din),
      .pend_v    (pend_v),
      .pend_addr (pend_addr),
      .pend_be   (pend_be),
      .pend_data (pend_data),
      .rd_addr   (cur_addr),
      .rd_word   (arr_word),
      .rd_merged (rd_word)
   );

   lw_sram_array #(
      .DEPTH  (DEPTH),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_arr (
      .clk   (clk),
      .we    (ce && pend_v),
      .waddr (pend_addr),
      .wbe   (pend_be),
      .wdata (pend_data),
      .raddr (cur_addr),
      .rdata (arr_word)
   );

   assign dout_vld = act && (op == lw_sram_pkg::OP_READ) && !oe_n;
   assign dout     = dout_vld ? rd_word : '0;

endmodule

// File: rtl/lw_burst_sram_chk.sv
module lw_burst_sram_chk #(
   parameter int DW = 36
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clk_en_n,
   input logic          sel_a_n,
   input logic          sel_b,
   input logic          sel_c_n,
   input logic          rw_n,
   input logic          adv,
   input logic          oe_n,
   input logic [DW-1:0] dout,
   input logic          dout_vld
);

   logic sel_ok;
   assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

   // R11: reset edge leaves no valid read data
   p_reset_idle_r11: assert property (@(posedge clk)
      !rst_n |=> !dout_vld);

   // R1: write command never shows read data in the next cycle
   p_write_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && sel_ok && !rw_n) |=> !dout_vld);

   // R2: read command gives valid data in the next cycle unless gated
   p_read_flow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && sel_ok && rw_n) |=> (oe_n || dout_vld));

   // R5: burst beat of a read stays a read
   p_burst_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv && dout_vld) |=> (oe_n || dout_vld));

   // R5: burst beat of a write or idle never turns into a read
   p_burst_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv && !oe_n && !dout_vld) |=> !dout_vld);

   // R8: frozen edge keeps outputs
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(oe_n) -> ($stable(dout_vld) && $stable(dout))));

   // R9: deselected command gives no data
   p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && !sel_ok) |=> !dout_vld);

   // R10: output enable high blocks valid data
   p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_vld);

   // R12: invalid output is all zeros
   p_zero_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_vld |-> (dout == '0));

endmodule

bind lw_burst_sram lw_burst_sram_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_en_n (clk_en_n),
   .sel_a_n  (sel_a_n),
   .sel_b    (sel_b),
   .sel_c_n  (sel_c_n),
   .rw_n     (rw_n),
   .adv      (adv),
   .oe_n     (oe_n),
   .dout     (dout),
   .dout_vld (dout_vld)
);

// File: tb/sim_lw_burst_sram.sv
module sim_lw_burst_sram;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int DW = 36;
   localparam int NV = 22;

   localparam logic [DW-1:0] ZW   = '0;
   localparam logic [DW-1:0] JUNK = {DW{1'b1}};
   localparam logic [DW-1:0] P0 = {9'h103, 9'h102, 9'h101, 9'h100};
   localparam logic [DW-1:0] P1 = {9'h113, 9'h112, 9'h111, 9'h110};
   localparam logic [DW-1:0] P2 = {9'h1F3, 9'h1F2, 9'h1F1, 9'h1F0};
   localparam logic [DW-1:0] PM = {9'h113, 9'h1F2, 9'h111, 9'h1F0};
   localparam logic [DW-1:0] W0 = {9'h033, 9'h032, 9'h031, 9'h030};
   localparam logic [DW-1:0] W1 = {9'h043, 9'h042, 9'h041, 9'h040};
   localparam logic [DW-1:0] W2 = {9'h053, 9'h052, 9'h051, 9'h050};
   localparam logic [DW-1:0] W3 = {9'h063, 9'h062, 9'h061, 9'h060};
   localparam logic [DW-1:0] Q1 = {9'h0C3, 9'h0C2, 9'h0C1, 9'h0C0};
   localparam logic [DW-1:0] Q2 = {9'h0D3, 9'h0D2, 9'h0D1, 9'h0D0};
   localparam logic [DW-1:0] Q3 = {9'h0E3, 9'h0E2, 9'h0E1, 9'h0E0};

   typedef struct packed {
      logic          adv;
      logic          rw_n;
      logic          sel;
      logic          ilv;
      logic [3:0]    be_n;
      logic [AW-1:0] addr;
      logic [DW-1:0] din;
      logic          ev;
      logic [DW-1:0] ed;
   } vec_t;

   // din of a row is the late data of the previous row's write
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 10'h010, ZW,   1'b0, ZW},
      '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 10'h011, P0,   1'b0, ZW},
      '{1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h010, P1,   1'b1, P0},
      '{1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h011, ZW,   1'b1, P1},
      '{1'b0, 1'b0, 1'b1, 1'b0, 4'hA, 10'h011, ZW,   1'b0, ZW},
      '{1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h011, P2,   1'b1, PM},
      '{1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 10'h011, ZW,   1'b0, ZW},
      '{1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h011, JUNK, 1'b1, PM},
      '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 10'h022, ZW,   1'b0, ZW},
      '{1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 10'h3FF, W0,   1'b0, ZW},
      '{1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 10'h155, W1,   1'b0, ZW},
      '{1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 10'h000, W2,   1'b0, ZW},
      '{1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h020, W3,   1'b1, W2},
      '{1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h021, ZW,   1'b1, W3},
      '{1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 10'h023, ZW,   1'b1, W1},
      '{1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 10'h000, ZW,   1'b1, W0},
      '{1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 10'h000, ZW,   1'b1, W3},
      '{1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 10'h000, ZW,   1'b1, W2},
      '{1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h021, ZW,   1'b1, W3},
      '{1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 10'h000, ZW,   1'b1, W0},
      '{1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 10'h000, ZW,   1'b1, W1},
      '{1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 10'h000, ZW,   1'b1, W2}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clk_en_n;
   logic          sel_a_n, sel_b, sel_c_n;
   logic          rw_n, adv, burst_ilv, oe_n;
   logic [AW-1:0] addr;
   logic [3:0]    byte_we_n;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          dout_vld;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lw_burst_sram u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en_n  (clk_en_n),
      .sel_a_n   (sel_a_n),
      .sel_b     (sel_b),
      .sel_c_n   (sel_c_n),
      .rw_n      (rw_n),
      .adv       (adv),
      .burst_ilv (burst_ilv),
      .addr      (addr),
      .byte_we_n (byte_we_n),
      .oe_n      (oe_n),
      .din       (din),
      .dout      (dout),
      .dout_vld  (dout_vld)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic apply(input logic a, input logic r, input logic s, input logic il,
                        input logic [3:0] be, input logic [AW-1:0] ad,
                        input logic [DW-1:0] d);
      adv       = a;
      rw_n      = r;
      {sel_a_n, sel_b, sel_c_n} = s ? 3'b010 : 3'b110;
      burst_ilv = il;
      byte_we_n = be;
      addr      = ad;
      din       = d;
   endtask

   task automatic check(input string req, input logic v_exp, input logic [DW-1:0] d_exp);
      nchk++;
      if (dout_vld !== v_exp || dout !== d_exp) begin
         nerr++;
         $display("FAIL %s: vld=%b dout=%h expected vld=%b dout=%h",
                  req, dout_vld, dout, v_exp, d_exp);
      end
   endtask

   function automatic string tag_of(input int i);
      if (i == 2)  return "R2 flow-through read";
      if (i < 4)   return "R1 late write";
      if (i < 6)   return "R4 lane enables";
      if (i < 8)   return "R9 deselected write";
      if (i < 14)  return "R5 burst ignores inputs";
      if (i < 18)  return "R7 interleaved order";
      return "R6 linear order";
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      clk_en_n = 1'b0;
      oe_n     = 1'b0;
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, '0, '0);
      tick();
      tick();
      // R11 / R12: reset state
      check("R11 reset state", 1'b0, ZW);
      rst_n = 1'b1;
      apply(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, '0, '0);
      tick();
      check("R12 idle output zero", 1'b0, ZW);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].adv, VECS[i].rw_n, VECS[i].sel, VECS[i].ilv,
               VECS[i].be_n, VECS[i].addr, VECS[i].din);
         tick();
         check(tag_of(i), VECS[i].ev, VECS[i].ed);
      end

      // R3: read right after write to the same address
      apply(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 10'h040, ZW);
      tick();
      check("R1 write cycle quiet", 1'b0, ZW);
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h040, Q1);
      tick();
      check("R3 read after write bypass", 1'b1, Q1);
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h040, ZW);
      tick();
      check("R3 word stored after bypass", 1'b1, Q1);

      // R10: asynchronous output enable
      oe_n = 1'b1;
      #1;
      check("R10 oe_n high gates output", 1'b0, ZW);
      oe_n = 1'b0;
      #1;
      check("R10 oe_n low restores output", 1'b1, Q1);
      oe_n = 1'b1;
      apply(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 10'h041, ZW);
      tick();
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h041, Q2);
      tick();
      check("R10 gated during read", 1'b0, ZW);
      oe_n = 1'b0;
      #1;
      check("R10 write done with oe_n high", 1'b1, Q2);

      // R8: clock enable freezes a pending data slot and a read output
      apply(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 10'h042, ZW);
      tick();
      clk_en_n = 1'b1;
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h040, JUNK);
      tick();
      check("R8 frozen during write", 1'b0, ZW);
      clk_en_n = 1'b0;
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h042, Q3);
      tick();
      check("R8 late data taken after hold", 1'b1, Q3);
      clk_en_n = 1'b1;
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h040, ZW);
      tick();
      check("R8 read output held", 1'b1, Q3);
      clk_en_n = 1'b0;

      // R5 / R9: deselect by sel_b, burst keeps deselect; then by sel_c_n
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h040, ZW);
      sel_b = 1'b0;
      tick();
      check("R9 deselect by sel_b", 1'b0, ZW);
      apply(1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 10'h040, ZW);
      tick();
      check("R5 burst keeps deselect", 1'b0, ZW);
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h040, ZW);
      sel_c_n = 1'b1;
      tick();
      check("R9 deselect by sel_c_n", 1'b0, ZW);

      // R11: reset in the middle of a read
      apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 10'h040, ZW);
      tick();
      check("R2 read before reset", 1'b1, Q1);
      rst_n = 1'b0;
      tick();
      check("R11 reset clears read", 1'b0, ZW);
      rst_n = 1'b1;
      tick();

      done = 1'b1;
      summary();
      $finish;
   end

endmodule